// File: doc/BRIEF.md
# Memory Request Hold and Stall Unit

This unit sits between a step-sequenced control unit and a memory whose access time may be one clock or many. The control unit issues read and write requests as pulses lasting one clock. The unit stretches each pulse into a strobe level that memory sees until memory reports completion. The unit also produces a run enable for the control step counter. That enable goes low only when three things hold at once: an access is outstanding, memory has not yet finished, and the current control step asks to wait for memory.

Everything runs on one rising-edge clock. The completion input is sampled synchronously. A request that arrives in the cycle after a wait step is delayed by one clock before it reaches memory. When read and write are requested in the same cycle, the read wins and a sticky error flag is raised for diagnosis.

Top module: `mem_req_hold`

## Requirements
- R1: While reset is high, both strobes are 0, the error flag is 0, and the run enable is 1, whatever the wait input is.
- R2: A read request pulse in a cycle not preceded by a wait cycle raises the read strobe at the next rising edge. The strobe then stays 1 for as long as the completion input stays 0.
- R3: When the completion input is 1 in a cycle and no new request sets the strobe, the held strobe is 0 after that cycle's rising edge.
- R4: Write requests use a separate hold path of their own that behaves like the read path. A write does not affect the read strobe.
- R5: The run enable is 0 exactly when a strobe is held, the completion input is 0, and the wait input is 1. Otherwise it is 1.
- R6: A request presented in the cycle right after a cycle with the wait input at 1 reaches its strobe one clock later than normal, that is, two rising edges after the request cycle.
- R7: When read and write are requested in the same cycle, the write is dropped and the read proceeds. The error flag rises at the next edge and stays at 1 until reset.
- R8: If a new request arrives in the same cycle as completion, the strobe stays at 1 across that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | One-cycle read request from the control unit |
| wr_req | input | 1 | One-cycle write request from the control unit |
| wait_req | input | 1 | Current step waits for memory completion |
| mem_done | input | 1 | Memory reports that the access is complete |
| mem_rd | output | 1 | Held read strobe to memory |
| mem_wr | output | 1 | Held write strobe to memory |
| run | output | 1 | Step counter enable; 0 stalls the sequencer |
| proto_err | output | 1 | Sticky flag for a simultaneous read and write request |

## Verification
The properties assume that reset is asserted at time zero with every request input low. They also assume that the completion input is never high in the same cycle as a request into a path whose deferred request is still waiting. The directed scenarios drive all inputs on the falling edge and issue each new access only after the previous one has been completed. This keeps those conditions true, so the checks can predict every edge exactly.

// File: rtl/mem_hold_pkg.sv
package mem_hold_pkg;
  localparam int unsigned CH_RD = 0;
  localparam int unsigned CH_WR = 1;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/mem_strobe_hold.sv
module mem_strobe_hold (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic defer_en,
  input  logic done,
  output logic strobe
);
  logic defer_q;
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      defer_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      defer_q  <= req & defer_en;
      strobe_q <= (req & ~defer_en) | defer_q | (strobe_q & ~done);
    end
  end

  assign strobe = strobe_q;
endmodule

// File: rtl/mem_stall_gen.sv
module mem_stall_gen #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              rst,
  input  logic [NUM_CH-1:0] held,
  input  logic              done,
  input  logic              wait_req,
  output logic              run
);
  logic busy;

  always_comb begin
    busy = |held;
    run  = rst | ~(busy & ~done & wait_req);
  end
endmodule

// File: rtl/mem_req_hold.sv
module mem_req_hold
  import mem_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic wr_req,
  input  logic wait_req,
  input  logic mem_done,
  output logic mem_rd,
  output logic mem_wr,
  output logic run,
  output logic proto_err
);
  logic              wait_d;
  logic              err_q;
  logic [NUM_CH-1:0] req_vec;
  logic [NUM_CH-1:0] held_vec;

  always_comb begin
    req_vec        = '0;
    req_vec[CH_RD] = rd_req;
    req_vec[CH_WR] = wr_req & ~rd_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_d <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wait_d <= wait_req;
      err_q  <= err_q | (rd_req & wr_req);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_path
    mem_strobe_hold u_hold (
      .clk      (clk),
      .rst      (rst),
      .req      (req_vec[g]),
      .defer_en (wait_d),
      .done     (mem_done),
      .strobe   (held_vec[g])
    );
  end

  mem_stall_gen #(.NUM_CH(NUM_CH)) u_stall (
    .rst      (rst),
    .held     (held_vec),
    .done     (mem_done),
    .wait_req (wait_req),
    .run      (run)
  );

  assign mem_rd    = held_vec[CH_RD];
  assign mem_wr    = held_vec[CH_WR];
  assign proto_err = err_q;
endmodule

// File: rtl/mem_req_hold_checker.sv
module mem_req_hold_checker (
  input logic clk,
  input logic rst,
  input logic rd_req,
  input logic wr_req,
  input logic wait_req,
  input logic mem_done,
  input logic mem_rd,
  input logic mem_wr,
  input logic run,
  input logic proto_err
);
  assert_read_set_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !$past(wait_req)) |=> mem_rd);

  assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_done) |=> mem_rd);

  assert_read_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_done && !rd_req && !$past(rd_req)) |=> !mem_rd);

  assert_write_set_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req && !$past(wait_req)) |=> mem_wr);

  assert_stall_cause_R5: assert property (@(posedge clk) disable iff (rst)
    !run |-> (wait_req && !mem_done));

  assert_idle_runs_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd && !mem_wr) |-> run);

  assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wr_req) |=> proto_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind mem_req_hold mem_req_hold_checker u_checker (.*);

// File: tb/mem_req_hold_bench.sv
module mem_req_hold_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0;
  logic wr_req = 1'b0;
  logic wait_req = 1'b0;
  logic mem_done = 1'b0;
  logic mem_rd, mem_wr, run, proto_err;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mem_req_hold u_mem_req_hold (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic wt, input logic dn);
    @(negedge clk);
    rd_req = r; wr_req = w; wait_req = wt; mem_done = dn;
    #1;
  endtask

  task automatic t_reset;
    cyc(0, 0, 1, 0);
    chk("R1 rd", mem_rd, 1'b0);
    chk("R1 wr", mem_wr, 1'b0);
    chk("R1 run", run, 1'b1);
    chk("R1 err", proto_err, 1'b0);
    rst = 1'b0;
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_read;
    cyc(1, 0, 0, 0);
    chk("R2 not yet", mem_rd, 1'b0);
    cyc(0, 0, 1, 0);
    chk("R2 set", mem_rd, 1'b1);
    chk("R5 stall", run, 1'b0);
    chk("R4 wr quiet", mem_wr, 1'b0);
    cyc(0, 0, 1, 0);
    chk("R2 held", mem_rd, 1'b1);
    cyc(0, 0, 1, 1);
    chk("R5 resume", run, 1'b1);
    chk("R2 held to done", mem_rd, 1'b1);
    cyc(0, 0, 0, 0);
    chk("R3 cleared", mem_rd, 1'b0);
  endtask

  task automatic t_defer;
    cyc(0, 0, 1, 0);
    chk("R5 idle wait runs", run, 1'b1);
    cyc(1, 0, 0, 0);
    chk("R6 none", mem_rd, 1'b0);
    cyc(0, 0, 0, 0);
    chk("R6 still delayed", mem_rd, 1'b0);
    cyc(0, 0, 0, 0);
    chk("R6 arrives", mem_rd, 1'b1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk("R3 defer cleared", mem_rd, 1'b0);
  endtask

  task automatic t_write;
    cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R4 set", mem_wr, 1'b1);
    chk("R4 rd quiet", mem_rd, 1'b0);
    chk("R5 write stall", run, 1'b0);
    cyc(0, 0, 0, 1);
    chk("R4 held", mem_wr, 1'b1);
    cyc(0, 0, 0, 0);
    chk("R4 cleared", mem_wr, 1'b0);
  endtask

  task automatic t_overlap;
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk("R8 kept", mem_rd, 1'b1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk("R8 then clear", mem_rd, 1'b0);
  endtask

  task automatic t_conflict;
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R7 write dropped", mem_wr, 1'b0);
    chk("R7 read kept", mem_rd, 1'b1);
    chk("R7 err", proto_err, 1'b1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk("R7 err sticky", proto_err, 1'b1);
    chk("R7 wr still 0", mem_wr, 1'b0);
  endtask

  initial begin
    t_reset();
    t_read();
    t_defer();
    t_write();
    t_overlap();
    t_conflict();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule